// File: doc/BRIEF.md
# Banked Data Memory Address Unit

This unit forms the physical data-memory address for a register file split into banks of 128 bytes. Each request carries a 7-bit register field taken from an instruction, two bank-select bits, and the contents of a pointer: one bank-pair bit plus an 8-bit pointer byte. A request whose register field names the reserved indirect slot takes its address from the pointer. Any other request uses the bank-select bits joined to the register field.

After the address is formed, the unit can fold a shared window at the top of each bank down to bank 0, so that those bytes appear in every bank. It then classifies the result as a special-function slot, a general-purpose byte, an access to no storage at all (a pointer that names the indirect slot itself), or an address beyond the banks that are built. The bank count and the shared window are parameters. All results are registered, so they appear one clock after the request.

Top module: `bankaddr_unit`

## Requirements
- R1: With req_valid high and op_fld not equal to 0x00, phys_addr becomes {bank_sel[1], bank_sel[0], op_fld}. Bit 8 is bank_sel[1], bit 7 is bank_sel[0] and bits 6:0 are op_fld. ind_path is 0.
- R2: With req_valid high and op_fld equal to 0x00, the pointer path is used and bank_sel is ignored. phys_addr becomes {ptr_hi, ptr_lo[7:0]}: ptr_hi=0 reaches banks 0 and 1, and ptr_hi=1 reaches banks 2 and 3. ind_path is 1.
- R3: On the pointer path, when ptr_lo[6:0] is 0x00 the pointer names the indirect slot itself. null_acc is then 1 and sfr_sel and gpr_sel are both 0, so a read sees zero and a write reaches nothing.
- R4: When SHARED_EN is 1, any resulting offset (phys_addr[6:0]) of 0x70 to 0x7F is reported in bank 0 (phys_addr[8:7]=0), whatever bank was selected. When SHARED_EN is 0, no folding takes place.
- R5: sfr_sel is 1 for offsets 0x00 to 0x1F and gpr_sel is 1 for offsets 0x20 to 0x7F. At most one of them is 1.
- R6: When NUM_BANKS is 2 or less, bank_sel[1] and ptr_hi are treated as 0.
- R7: When the resulting bank number is NUM_BANKS or higher, unimpl is 1 and sfr_sel and gpr_sel are both 0.
- R8: Results are due on the first rising edge after a request. addr_valid follows req_valid with one cycle of delay. When req_valid is low, the other outputs keep their previous values.
- R9: A synchronous active-high reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| op_fld | input | 7 | Register field from the instruction |
| bank_sel | input | 2 | Bank-select bits for the direct path |
| ptr_hi | input | 1 | Bank-pair bit for the pointer path |
| ptr_lo | input | 8 | Pointer byte |
| addr_valid | output | 1 | Result valid, one cycle after req_valid |
| phys_addr | output | 9 | Physical data-memory address |
| sfr_sel | output | 1 | Address is a special-function slot |
| gpr_sel | output | 1 | Address is a general-purpose byte |
| null_acc | output | 1 | Pointer names the indirect slot; no storage is reached |
| unimpl | output | 1 | Bank is not implemented |
| ind_path | output | 1 | Address came from the pointer |

## Verification
Every result is due exactly one rising edge after the request that produced it. The bench drives each request at a falling edge and samples all outputs at the next falling edge, which falls after that single registered stage. In the hold check, req_valid is dropped with the inputs changed, and the bench confirms one falling edge later that addr_valid is 0 and phys_addr is unchanged. Two extra instances, one with three banks and no shared window and one with two banks, receive the same stimulus at the same times.

// File: rtl/bau_pkg.sv
package bau_pkg;
  localparam int BANK_W = 2;

  typedef enum logic [1:0] {
    SLOT_NONE = 2'd0,
    SLOT_SFR  = 2'd1,
    SLOT_GPR  = 2'd2
  } slot_e;
endpackage

// File: rtl/bau_path_sel.sv
module bau_path_sel
  import bau_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int OFS_W     = 7,
  parameter int IND_OFS   = 0
) (
  input  logic [OFS_W-1:0]  op_fld,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              ptr_hi,
  input  logic [OFS_W:0]    ptr_lo,
  output logic [BANK_W-1:0] bank,
  output logic [OFS_W-1:0]  ofs,
  output logic              ind,
  output logic              nul
);
  localparam logic HI_EN = (NUM_BANKS > 2);
  localparam logic [OFS_W-1:0] IND_SLOT = OFS_W'(IND_OFS);

  logic hi_dir, hi_ind;

  always_comb begin
    hi_dir = bank_sel[1] & HI_EN;
    hi_ind = ptr_hi & HI_EN;
    ind    = (op_fld == IND_SLOT);
    if (ind) begin
      bank = {hi_ind, ptr_lo[OFS_W]};
      ofs  = ptr_lo[OFS_W-1:0];
    end else begin
      bank = {hi_dir, bank_sel[0]};
      ofs  = op_fld;
    end
    nul = ind && (ptr_lo[OFS_W-1:0] == IND_SLOT);
  end
endmodule

// File: rtl/bau_fold.sv
module bau_fold
  import bau_pkg::*;
#(
  parameter int SHARED_EN   = 1,
  parameter int OFS_W       = 7,
  parameter int SHARED_BASE = 112
) (
  input  logic [BANK_W-1:0] bank_in,
  input  logic [OFS_W-1:0]  ofs,
  output logic [BANK_W-1:0] bank_out
);
  localparam logic [OFS_W-1:0] BASE = OFS_W'(SHARED_BASE);

  generate
    if (SHARED_EN != 0) begin : g_shared
      always_comb bank_out = (ofs >= BASE) ? '0 : bank_in;
    end else begin : g_plain
      always_comb bank_out = bank_in;
    end
  endgenerate
endmodule

// File: rtl/bau_class.sv
module bau_class
  import bau_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int OFS_W     = 7,
  parameter int SFR_LIMIT = 32
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              nul,
  output slot_e             slot,
  output logic              unimpl
);
  localparam logic [OFS_W-1:0] SFR_END = OFS_W'(SFR_LIMIT);

  generate
    if (NUM_BANKS < (1 << BANK_W)) begin : g_partial
      always_comb unimpl = (bank >= BANK_W'(NUM_BANKS));
    end else begin : g_full
      always_comb unimpl = 1'b0;
    end
  endgenerate

  always_comb begin
    if (nul || unimpl)      slot = SLOT_NONE;
    else if (ofs < SFR_END) slot = SLOT_SFR;
    else                    slot = SLOT_GPR;
  end
endmodule

// File: rtl/bankaddr_unit.sv
module bankaddr_unit
  import bau_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int SHARED_EN   = 1,
  parameter int OFS_W       = 7,
  parameter int SFR_LIMIT   = 32,
  parameter int SHARED_BASE = 112,
  parameter int IND_OFS     = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [OFS_W-1:0]   op_fld,
  input  logic [1:0]         bank_sel,
  input  logic               ptr_hi,
  input  logic [OFS_W:0]     ptr_lo,
  output logic               addr_valid,
  output logic [OFS_W+1:0]   phys_addr,
  output logic               sfr_sel,
  output logic               gpr_sel,
  output logic               null_acc,
  output logic               unimpl,
  output logic               ind_path
);
  logic [BANK_W-1:0] bank_raw, bank_fold;
  logic [OFS_W-1:0]  ofs;
  logic              ind, nul, unimpl_c;
  slot_e             slot;

  bau_path_sel #(.NUM_BANKS(NUM_BANKS), .OFS_W(OFS_W), .IND_OFS(IND_OFS)) u_path (
    .op_fld(op_fld), .bank_sel(bank_sel), .ptr_hi(ptr_hi), .ptr_lo(ptr_lo),
    .bank(bank_raw), .ofs(ofs), .ind(ind), .nul(nul)
  );

  bau_fold #(.SHARED_EN(SHARED_EN), .OFS_W(OFS_W), .SHARED_BASE(SHARED_BASE)) u_fold (
    .bank_in(bank_raw), .ofs(ofs), .bank_out(bank_fold)
  );

  bau_class #(.NUM_BANKS(NUM_BANKS), .OFS_W(OFS_W), .SFR_LIMIT(SFR_LIMIT)) u_class (
    .bank(bank_fold), .ofs(ofs), .nul(nul), .slot(slot), .unimpl(unimpl_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_valid <= 1'b0;
      phys_addr  <= '0;
      sfr_sel    <= 1'b0;
      gpr_sel    <= 1'b0;
      null_acc   <= 1'b0;
      unimpl     <= 1'b0;
      ind_path   <= 1'b0;
    end else begin
      addr_valid <= req_valid;
      if (req_valid) begin
        phys_addr <= {bank_fold, ofs};
        sfr_sel   <= (slot == SLOT_SFR);
        gpr_sel   <= (slot == SLOT_GPR);
        null_acc  <= nul;
        unimpl    <= unimpl_c;
        ind_path  <= ind;
      end
    end
  end
endmodule

// File: rtl/bau_chk.sv
module bau_chk #(
  parameter int NUM_BANKS   = 4,
  parameter int SHARED_EN   = 1,
  parameter int OFS_W       = 7,
  parameter int SHARED_BASE = 112,
  parameter int IND_OFS     = 0
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [OFS_W-1:0] op_fld,
  input logic [OFS_W:0]   ptr_lo,
  input logic             addr_valid,
  input logic [OFS_W+1:0] phys_addr,
  input logic             sfr_sel,
  input logic             gpr_sel,
  input logic             null_acc,
  input logic             unimpl
);
  localparam logic [OFS_W-1:0] IND_SLOT = OFS_W'(IND_OFS);
  localparam logic [OFS_W-1:0] BASE = OFS_W'(SHARED_BASE);

  // R1
  direct_ofs_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(req_valid) && $past(op_fld) != IND_SLOT) |-> phys_addr[OFS_W-1:0] == $past(op_fld));

  // R2
  ptr_ofs_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(req_valid) && $past(op_fld) == IND_SLOT) |-> phys_addr[OFS_W-1:0] == $past(ptr_lo[OFS_W-1:0]));

  // R3
  null_no_sel_chk: assert property (@(posedge clk) disable iff (rst)
    null_acc |-> !sfr_sel && !gpr_sel);

  // R4
  shared_fold_chk: assert property (@(posedge clk) disable iff (rst)
    ((SHARED_EN != 0) && addr_valid && phys_addr[OFS_W-1:0] >= BASE) |-> phys_addr[OFS_W+1:OFS_W] == 2'b00);

  // R5
  sel_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(sfr_sel && gpr_sel));

  // R6
  two_bank_chk: assert property (@(posedge clk) disable iff (rst)
    ((NUM_BANKS <= 2) && addr_valid) |-> !phys_addr[OFS_W+1]);

  // R7
  unimpl_no_sel_chk: assert property (@(posedge clk) disable iff (rst)
    unimpl |-> !sfr_sel && !gpr_sel);

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> addr_valid);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && !$past(rst)) |=> $stable(phys_addr) && !addr_valid);
endmodule

bind bankaddr_unit bau_chk #(
  .NUM_BANKS(NUM_BANKS), .SHARED_EN(SHARED_EN), .OFS_W(OFS_W),
  .SHARED_BASE(SHARED_BASE), .IND_OFS(IND_OFS)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .op_fld(op_fld), .ptr_lo(ptr_lo),
  .addr_valid(addr_valid), .phys_addr(phys_addr), .sfr_sel(sfr_sel),
  .gpr_sel(gpr_sel), .null_acc(null_acc), .unimpl(unimpl)
);

// File: tb/tb_bankaddr_unit.sv
module tb_bankaddr_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [6:0] op_fld = '0;
  logic [1:0] bank_sel = '0;
  logic       ptr_hi = 1'b0;
  logic [7:0] ptr_lo = '0;

  logic       av, sf, gp, nu, un, ip;
  logic [8:0] pa;
  logic       av3, sf3, gp3, nu3, un3, ip3;
  logic [8:0] pa3;
  logic       av2, sf2, gp2, nu2, un2, ip2;
  logic [8:0] pa2;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bankaddr_unit dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .op_fld(op_fld), .bank_sel(bank_sel),
    .ptr_hi(ptr_hi), .ptr_lo(ptr_lo), .addr_valid(av), .phys_addr(pa), .sfr_sel(sf),
    .gpr_sel(gp), .null_acc(nu), .unimpl(un), .ind_path(ip)
  );

  bankaddr_unit #(.NUM_BANKS(3), .SHARED_EN(0)) dut_b3 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .op_fld(op_fld), .bank_sel(bank_sel),
    .ptr_hi(ptr_hi), .ptr_lo(ptr_lo), .addr_valid(av3), .phys_addr(pa3), .sfr_sel(sf3),
    .gpr_sel(gp3), .null_acc(nu3), .unimpl(un3), .ind_path(ip3)
  );

  bankaddr_unit #(.NUM_BANKS(2), .SHARED_EN(1)) dut_b2 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .op_fld(op_fld), .bank_sel(bank_sel),
    .ptr_hi(ptr_hi), .ptr_lo(ptr_lo), .addr_valid(av2), .phys_addr(pa2), .sfr_sel(sf2),
    .gpr_sel(gp2), .null_acc(nu2), .unimpl(un2), .ind_path(ip2)
  );

  // entry: op[30:24] bsel[23:22] hi[21] lo[20:13] addr[12:4] sfr[3] gpr[2] null[1] ind[0]
  localparam int NV = 12;
  localparam logic [30:0] VECS [NV] = '{
    {7'h25, 2'd0, 1'b0, 8'h00, 9'h025, 4'b0100},  // R1 bank 0 gpr
    {7'h05, 2'd2, 1'b0, 8'h00, 9'h105, 4'b1000},  // R1 bank 2 sfr
    {7'h40, 2'd3, 1'b0, 8'h00, 9'h1C0, 4'b0100},  // R1 bank 3
    {7'h1F, 2'd1, 1'b0, 8'h00, 9'h09F, 4'b1000},  // R5 last sfr
    {7'h20, 2'd1, 1'b0, 8'h00, 9'h0A0, 4'b0100},  // R5 first gpr
    {7'h75, 2'd3, 1'b0, 8'h00, 9'h075, 4'b0100},  // R4 folded
    {7'h00, 2'd0, 1'b1, 8'hA4, 9'h1A4, 4'b0101},  // R2 bank 3 via pointer
    {7'h00, 2'd0, 1'b0, 8'h85, 9'h085, 4'b1001},  // R2 bank 1 sfr
    {7'h00, 2'd0, 1'b1, 8'h7A, 9'h07A, 4'b0101},  // R4 folded via pointer
    {7'h00, 2'd0, 1'b0, 8'h80, 9'h080, 4'b0011},  // R3 pointer names slot
    {7'h00, 2'd3, 1'b0, 8'h30, 9'h030, 4'b0101},  // R2 bank_sel ignored
    {7'h6F, 2'd2, 1'b0, 8'h00, 9'h16F, 4'b0100}   // R4 below window
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [6:0] op, input logic [1:0] bs, input logic hi, input logic [7:0] lo);
    @(negedge clk);
    req_valid = 1'b1; op_fld = op; bank_sel = bs; ptr_hi = hi; ptr_lo = lo;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset outs", {27'd0, av, sf, gp, nu, un, ip}, 32'd0);
    chk("R9 reset addr", {23'd0, pa}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i][30:24], VECS[i][23:22], VECS[i][21], VECS[i][20:13]);
      chk($sformatf("R1/R2 addr vec%0d", i), {23'd0, pa}, {23'd0, VECS[i][12:4]});
      chk($sformatf("R5/R3 flags vec%0d", i), {28'd0, sf, gp, nu, ip}, {28'd0, VECS[i][3:0]});
      chk($sformatf("R8 valid vec%0d", i), {31'd0, av}, 32'd1);
    end

    // R8 hold with req_valid low
    issue(7'h33, 2'd1, 1'b0, 8'h00);
    req_valid = 1'b0; op_fld = 7'h44; bank_sel = 2'd2;
    @(negedge clk);
    chk("R8 valid drops", {31'd0, av}, 32'd0);
    chk("R8 addr held", {23'd0, pa}, 32'h0B3);

    // R7 three banks, no shared window: bank 3 unimplemented
    issue(7'h30, 2'd3, 1'b0, 8'h00);
    chk("R7 unimpl direct", {29'd0, un3, sf3, gp3}, 32'b100);
    chk("R7 addr b3", {23'd0, pa3}, 32'h1B0);
    chk("R7 default impl", {31'd0, un}, 32'd0);
    issue(7'h00, 2'd0, 1'b1, 8'h90);
    chk("R7 unimpl pointer", {29'd0, un3, sf3, gp3}, 32'b100);
    // R4 no fold when disabled
    issue(7'h75, 2'd2, 1'b0, 8'h00);
    chk("R4 no fold addr", {23'd0, pa3}, 32'h175);
    chk("R4 no fold sel", {29'd0, un3, sf3, gp3}, 32'b001);

    // R6 two banks: bank_sel[1] and ptr_hi forced low
    issue(7'h10, 2'd3, 1'b0, 8'h00);
    chk("R6 direct b2", {23'd0, pa2}, 32'h090);
    chk("R6 sfr b2", {30'd0, sf2, un2}, 32'b10);
    issue(7'h00, 2'd0, 1'b1, 8'h50);
    chk("R6 pointer b2", {23'd0, pa2}, 32'h050);

    // R9 reset again mid-run
    rst = 1'b1;
    @(negedge clk);
    chk("R9 reclear", {18'd0, av, sf, gp, nu, un, ip, pa}, 32'd0);
    rst = 1'b0; req_valid = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule